// File: doc/BRIEF.md
# Three-Stage Pipeline Sequencer

This block is the control core of an in-order processor with fetch, decode and execute stages and a single memory port. The port serves both instruction fetch and load/store data, so the block picks the port address each cycle. It keeps the fetch address and the decode and execute stage registers, and raises stall and flush. It also returns the value an executing instruction sees when it reads the program counter. The register file and ALU lie outside the block. The datapath hands back one word, `exe_result`, which the block uses as the load/store address or as a computed jump target.

The memory port is a synchronous RAM: an address driven in one cycle returns its word on `mem_rdata` in the next cycle. A small decoder works on a test encoding. The top two bits hold the condition and the next two hold the class. Execute runs as a two-state machine. `ST_RUN` handles ordinary execute cycles, and for a memory instruction it is also the address cycle. `ST_DATA` is the single data-access cycle. The transition `RUN->DATA` is taken when a load or store in execute passes its condition. `DATA->RUN` is always taken after one cycle. `RUN->RUN` is taken in every other case.

Top module: `pipe3_seq`

## Requirements
- R1: After reset the port fetches address 0, and decode and execute are empty. The first instruction reaches execute in the third cycle after reset is released, so there are two bubble cycles.
- R2: With no memory access and no redirect, the fetch address rises by 4 each cycle, each stage passes its content to the next, and one instruction completes per clock (`exe_retire`).
- R3: Bits [31:30] of the instruction give the condition: 0 always, 1 never, 2 when `flag_z` is 1, 3 when `flag_z` is 0. Bits [29:28] give the class: 0 ALU, 1 load, 2 store, 3 branch. For ALU, bit 27 set means the PC is the destination. For branch, bits [26:0] are a signed word offset.
- R4: A load or store that passes its condition spends two cycles in execute. In the address cycle `exe_result` is captured. In the following data cycle the port carries that address with `mem_data_cyc` = 1, and `mem_we` = 1 only for a store.
- R5: During the data cycle no fetch is issued (`fetch_valid` = 0), and fetch and decode keep their contents. `stall` is high in both the address and data cycles. The instruction behind the load enters execute right after the data cycle, with no bubble.
- R6: A taken branch raises `flush` in its execute cycle. In the next cycle decode and execute are empty and the port fetches own address + 8 + 4 x offset.
- R7: An ALU instruction writing the PC that passes its condition flushes the same way, and fetching restarts at `exe_result` with bits [1:0] cleared.
- R8: `exe_pc_read` equals the executing instruction's address plus 8.
- R9: An instruction of any class whose condition fails takes one execute cycle as a no-op. It raises no flush, no stall and no data access.
- R10: In the address cycle of a load or store, the port still issues the next instruction fetch (`fetch_valid` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address on the shared port |
| mem_data_cyc | output | 1 | Port is doing a data access this cycle |
| mem_we | output | 1 | Data access is a write |
| mem_rdata | input | 32 | Word read for the previous cycle's address |
| exe_result | input | 32 | Datapath result for the instruction in execute |
| flag_z | input | 1 | Zero flag used for condition evaluation |
| fetch_valid | output | 1 | Port is fetching an instruction this cycle |
| dec_valid | output | 1 | Decode holds an instruction |
| exe_valid | output | 1 | Execute holds an instruction |
| stall | output | 1 | Fetch and decode are held by a memory instruction |
| flush | output | 1 | Taken redirect; decode and fetch are discarded |
| exe_retire | output | 1 | Instruction in execute completes this cycle |
| exe_pc_read | output | 32 | PC value visible to the executing instruction |

## Verification
The bench runs a looping program that mixes back-to-back loads, a store, condition-failed memory, branch and PC-writing instructions, and forward and backward branches. `flag_z` toggles pseudo-randomly throughout. A design that let fetch use the port during the data cycle would show the fetch address on the port where the data address belongs. A design that let decode move on during the address cycle would lose or repeat an instruction in execute. A design that redirected on a failed condition, or that ran a failed load as a data access, would break the fetch sequence or raise `mem_data_cyc`. A wrong branch base or a missing low-bit clear on a PC write would restart fetch at the wrong address. A PC read that used the own address, or an address four bytes ahead, would not match `exe_pc_read`.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

    // Branch offset occupies everything below the PC-destination bit.
    localparam int OFF_W = 27;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_STORE  = 2'd2,
        CLS_BRANCH = 2'd3
    } ins_cls_e;

    typedef enum logic [1:0] {
        CND_ALWAYS = 2'd0,
        CND_NEVER  = 2'd1,
        CND_ZSET   = 2'd2,
        CND_ZCLR   = 2'd3
    } ins_cnd_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_DATA = 1'b1
    } seq_st_e;

    typedef struct packed {
        ins_cnd_e         cnd;
        ins_cls_e         cls;
        logic             wr_pc;
        logic [OFF_W-1:0] off;
    } ins_dec_t;

endpackage

// File: rtl/pipe3_decode.sv
module pipe3_decode
    import pipe3_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic [IW-1:0] ir,
    output ins_dec_t      dec
);

    localparam int CND_MSB = IW - 1;
    localparam int CLS_MSB = IW - 3;
    localparam int WRPC_B  = IW - 5;

    always_comb begin
        dec.cnd   = ins_cnd_e'(ir[CND_MSB -: 2]);
        dec.cls   = ins_cls_e'(ir[CLS_MSB -: 2]);
        dec.wr_pc = ir[WRPC_B] && (ir[CLS_MSB -: 2] == 2'b00);
        dec.off   = ir[OFF_W-1:0];
    end

endmodule

// File: rtl/pipe3_fetch.sv
module pipe3_fetch #(
    parameter int AW = 32,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] STEP = AW'(IW / 8);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (redirect) begin
            pc <= target;
        end else if (go) begin
            pc <= pc + STEP;
        end
    end

endmodule

// File: rtl/pipe3_ctl.sv
module pipe3_ctl
    import pipe3_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     e_valid,
    input  ins_cnd_e e_cnd,
    input  ins_cls_e e_cls,
    input  logic     e_wr_pc,
    input  logic     flag_z,
    output seq_st_e  st,
    output logic     cond_ok,
    output logic     start_mem,
    output logic     take_jump,
    output logic     retire,
    output logic     in_data
);

    seq_st_e st_nx;
    logic    is_mem;
    logic    is_jump;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_RUN;
        end else begin
            st <= st_nx;
        end
    end

    // Outputs and next state
    always_comb begin
        unique case (e_cnd)
            CND_ALWAYS: cond_ok = 1'b1;
            CND_NEVER:  cond_ok = 1'b0;
            CND_ZSET:   cond_ok = flag_z;
            CND_ZCLR:   cond_ok = !flag_z;
        endcase
        is_mem    = (e_cls == CLS_LOAD) || (e_cls == CLS_STORE);
        is_jump   = (e_cls == CLS_BRANCH) || ((e_cls == CLS_ALU) && e_wr_pc);
        start_mem = 1'b0;
        take_jump = 1'b0;
        retire    = 1'b0;
        in_data   = 1'b0;
        st_nx     = st;
        unique case (st)
            ST_RUN: begin
                start_mem = e_valid && cond_ok && is_mem;
                take_jump = e_valid && cond_ok && is_jump;
                retire    = e_valid && !start_mem;
                st_nx     = start_mem ? ST_DATA : ST_RUN;
            end
            ST_DATA: begin
                in_data = 1'b1;
                retire  = 1'b1;
                st_nx   = ST_RUN;
            end
        endcase
    end

    // R4: the data cycle never repeats
    p_data_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA) |=> (st == ST_RUN));

endmodule

// File: rtl/pipe3_seq.sv
module pipe3_seq
    import pipe3_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_data_cyc,
    output logic          mem_we,
    input  logic [IW-1:0] mem_rdata,
    input  logic [AW-1:0] exe_result,
    input  logic          flag_z,
    output logic          fetch_valid,
    output logic          dec_valid,
    output logic          exe_valid,
    output logic          stall,
    output logic          flush,
    output logic          exe_retire,
    output logic [AW-1:0] exe_pc_read
);

    localparam int            STEP   = IW / 8;
    localparam int            SH     = $clog2(STEP);
    localparam int            SEXT_W = AW - OFF_W - SH;
    localparam logic [AW-1:0] AHEAD  = AW'(2 * STEP);

    // Stage state
    logic [AW-1:0] f_pc;
    logic          d_valid;
    logic [AW-1:0] d_pc;
    logic          d_fresh;
    logic [IW-1:0] d_ir_q;
    logic [IW-1:0] d_ir;
    ins_dec_t      d_dec;
    logic          e_valid;
    logic [AW-1:0] e_pc;
    ins_dec_t      e_dec;
    logic [AW-1:0] data_addr_q;
    logic          data_we_q;

    // Control
    seq_st_e       st;
    logic          cond_ok;
    logic          start_mem;
    logic          take_jump;
    logic          retire;
    logic          in_data;
    logic [AW-1:0] br_off;
    logic [AW-1:0] jump_tgt;

    // Decode word: straight from the port in the cycle after its fetch,
    // otherwise the copy kept while the port carried other traffic.
    assign d_ir = d_fresh ? mem_rdata : d_ir_q;

    pipe3_decode #(.IW(IW)) u_decode (
        .ir  (d_ir),
        .dec (d_dec)
    );

    pipe3_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .e_valid   (e_valid),
        .e_cnd     (e_dec.cnd),
        .e_cls     (e_dec.cls),
        .e_wr_pc   (e_dec.wr_pc),
        .flag_z    (flag_z),
        .st        (st),
        .cond_ok   (cond_ok),
        .start_mem (start_mem),
        .take_jump (take_jump),
        .retire    (retire),
        .in_data   (in_data)
    );

    always_comb begin
        br_off = {{SEXT_W{e_dec.off[OFF_W-1]}}, e_dec.off, {SH{1'b0}}};
        if (e_dec.cls == CLS_BRANCH) begin
            jump_tgt = e_pc + AHEAD + br_off;
        end else begin
            jump_tgt = {exe_result[AW-1:SH], {SH{1'b0}}};
        end
    end

    pipe3_fetch #(.AW(AW), .IW(IW)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (!start_mem),
        .redirect (take_jump),
        .target   (jump_tgt),
        .pc       (f_pc)
    );

    // Decode stage register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_valid <= 1'b0;
            d_pc    <= '0;
            d_fresh <= 1'b0;
            d_ir_q  <= '0;
        end else if (take_jump) begin
            d_valid <= 1'b0;
            d_fresh <= 1'b0;
        end else if (start_mem) begin
            d_fresh <= 1'b0;
            d_ir_q  <= d_ir;
        end else begin
            d_valid <= 1'b1;
            d_pc    <= f_pc;
            d_fresh <= !in_data;
            d_ir_q  <= mem_rdata;
        end
    end

    // Execute stage register and captured data address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_valid     <= 1'b0;
            e_pc        <= '0;
            e_dec       <= '0;
            data_addr_q <= '0;
            data_we_q   <= 1'b0;
        end else if (take_jump) begin
            e_valid <= 1'b0;
        end else if (start_mem) begin
            data_addr_q <= exe_result;
            data_we_q   <= (e_dec.cls == CLS_STORE);
        end else begin
            e_valid <= d_valid;
            e_pc    <= d_pc;
            e_dec   <= d_dec;
        end
    end

    assign mem_addr     = in_data ? data_addr_q : f_pc;
    assign mem_data_cyc = in_data;
    assign mem_we       = in_data && data_we_q;
    assign fetch_valid  = !in_data;
    assign dec_valid    = d_valid;
    assign exe_valid    = e_valid;
    assign stall        = start_mem || in_data;
    assign flush        = take_jump;
    assign exe_retire   = retire;
    assign exe_pc_read  = e_pc + AHEAD;

    // Cycles since reset, saturating, for the start-up check
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    p_reset_bubbles_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 2'd2) |-> !exe_valid);

    p_data_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_mem |=> (mem_data_cyc && (mem_addr == $past(exe_result))));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_data_cyc |-> ($stable(d_pc) && $stable(e_pc) && $stable(f_pc)));

    p_flush_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!dec_valid && !exe_valid && (mem_addr == $past(jump_tgt))));

    p_two_ahead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid |-> (exe_pc_read == f_pc));

    p_fail_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_valid && !mem_data_cyc && !cond_ok) |=> !mem_data_cyc);

endmodule

// File: tb/pipe3_seq_bench.sv
module pipe3_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] mem_addr;
    logic        mem_data_cyc;
    logic        mem_we;
    logic [31:0] mem_rdata = '0;
    logic [31:0] exe_result;
    logic        flag_z;
    logic        fetch_valid, dec_valid, exe_valid, stall, flush, exe_retire;
    logic [31:0] exe_pc_read;

    int checks   = 0;
    int failures = 0;

    logic [31:0] mem [0:255];

    always #4 clk = ~clk;

    pipe3_seq u_pipe3_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_addr     (mem_addr),
        .mem_data_cyc (mem_data_cyc),
        .mem_we       (mem_we),
        .mem_rdata    (mem_rdata),
        .exe_result   (exe_result),
        .flag_z       (flag_z),
        .fetch_valid  (fetch_valid),
        .dec_valid    (dec_valid),
        .exe_valid    (exe_valid),
        .stall        (stall),
        .flush        (flush),
        .exe_retire   (exe_retire),
        .exe_pc_read  (exe_pc_read)
    );

    // Synchronous single-port memory
    always @(posedge clk) mem_rdata <= mem[mem_addr[9:2]];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit cpass(input logic [31:0] w, input bit z);
        case (w[31:30])
            2'd0: return 1'b1;
            2'd1: return 1'b0;
            2'd2: return z;
            default: return !z;
        endcase
    endfunction

    // Behavioural reference model
    bit          mst, mdv, mev, mwe;
    logic [31:0] mf, mdp, mep, maddr;
    string       addr_tag = "R1";
    int          n_store = 0, n_load = 0, n_br = 0, n_pcw = 0, n_fail = 0;

    always @(posedge clk) begin
        logic [31:0] w;
        logic [31:0] off;
        bit pass;
        if (!rst_n) begin
            mst = 0; mdv = 0; mev = 0; mwe = 0;
            mf = 0; mdp = 0; mep = 0; maddr = 0;
            addr_tag = "R1";
        end else begin
            w    = mem[mep[9:2]];
            pass = cpass(w, flag_z);
            if (mst) begin
                mst = 0; mev = mdv; mep = mdp; mdv = 1; mdp = mf; mf = mf + 4;
                addr_tag = "R5";
            end else if (mev && pass && (w[29:28] == 2'd3 || (w[29:28] == 2'd0 && w[27]))) begin
                if (w[29:28] == 2'd3) begin
                    off = {{5{w[26]}}, w[26:0]};
                    mf = mep + 32'd8 + (off << 2);
                    addr_tag = "R6"; n_br++;
                end else begin
                    mf = {exe_result[31:2], 2'b00};
                    addr_tag = "R7"; n_pcw++;
                end
                mdv = 0; mev = 0;
            end else if (mev && pass && (w[29:28] == 2'd1 || w[29:28] == 2'd2)) begin
                mst = 1; maddr = exe_result; mwe = (w[29:28] == 2'd2);
                addr_tag = "R4";
                if (mwe) n_store++; else n_load++;
            end else begin
                if (mev && !pass && w[29:28] != 2'd0) n_fail++;
                mev = mdv; mep = mdp; mdv = 1; mdp = mf; mf = mf + 4;
                addr_tag = "R2";
            end
        end
    end

    task automatic compare();
        logic [31:0] w;
        bit pass, emem, ejmp;
        w    = mem[mep[9:2]];
        pass = cpass(w, flag_z);
        emem = !mst && mev && pass && (w[29:28] == 2'd1 || w[29:28] == 2'd2);
        ejmp = !mst && mev && pass && (w[29:28] == 2'd3 || (w[29:28] == 2'd0 && w[27]));
        chk(addr_tag, "mem_addr", mem_addr, mst ? maddr : mf);
        chk("R4", "mem_data_cyc", 32'(mem_data_cyc), 32'(mst));
        chk("R4", "mem_we", 32'(mem_we), 32'(mst && mwe));
        chk(emem ? "R10" : "R5", "fetch_valid", 32'(fetch_valid), 32'(!mst));
        chk("R3", "stall", 32'(stall), 32'(emem || mst));
        chk((mev && !pass) ? "R9" : "R6", "flush", 32'(flush), 32'(ejmp));
        chk("R2", "dec_valid", 32'(dec_valid), 32'(mdv));
        chk("R2", "exe_valid", 32'(exe_valid), 32'(mev));
        chk("R2", "exe_retire", 32'(exe_retire), 32'(mev && !emem));
        if (mev) chk("R8", "exe_pc_read", exe_pc_read, mep + 32'd8);
    endtask

    initial begin
        logic [7:0] lfsr = 8'hA5;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0000_0000;
        mem[0]  = 32'h0000_0000;  // ALU
        mem[1]  = 32'h0000_0000;  // ALU
        mem[2]  = 32'h1000_0000;  // load, always
        mem[3]  = 32'h4800_0000;  // PC-writing ALU, never
        mem[4]  = 32'h6000_0000;  // store, never
        mem[5]  = 32'h9000_0000;  // load, when Z set
        mem[6]  = 32'h2000_0000;  // store, always
        mem[7]  = 32'h1000_0000;  // load, always (back to back)
        mem[8]  = 32'h7000_0000;  // branch, never
        mem[9]  = 32'h3000_0003;  // branch +3 words -> 0x38
        mem[14] = 32'h0800_0000;  // PC-writing ALU -> exe_result
        mem[18] = 32'hB7FF_FFEC;  // branch to 0 when Z set
        mem[19] = 32'h37FF_FFEB;  // branch to 0
        rst_n = 1'b0; flag_z = 1'b0; exe_result = 32'h0;
        repeat (3) @(negedge clk);
        #2;
        chk("R1", "reset mem_addr", mem_addr, 32'h0);
        chk("R1", "reset dec_valid", 32'(dec_valid), 32'h0);
        chk("R1", "reset exe_valid", 32'(exe_valid), 32'h0);
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (k == 0) rst_n = 1'b1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            flag_z = lfsr[0];
            exe_result = 32'h40 | ((k % 2 == 1) ? 32'h6 : 32'h1);
            #2;
            if (k < 2) chk("R1", "bubble exe_valid", 32'(exe_valid), 32'h0);
            if (k == 2) begin
                chk("R1", "first exe_valid", 32'(exe_valid), 32'h1);
                chk("R1", "first exe_pc_read", exe_pc_read, 32'h8);
            end
            compare();
        end
        chk("R4", "stores seen", 32'(n_store > 0), 32'h1);
        chk("R5", "loads seen", 32'(n_load > 0), 32'h1);
        chk("R6", "branches seen", 32'(n_br > 0), 32'h1);
        chk("R7", "pc writes seen", 32'(n_pcw > 0), 32'h1);
        chk("R9", "failed ops seen", 32'(n_fail > 0), 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule